// File: doc/BRIEF.md
# Partly Serial FIR Filter with Run-Time Coefficient Reload

This block is a direct-form FIR filter. Its taps are split into two partitions, and each partition owns a single multiply-accumulate unit. The system clock runs at a fixed multiple of the sample rate, and that multiple equals the length of the longer partition. With the default 7 + 4 split (11 taps), one input sample is accepted every 7 clocks. Each partition walks its taps one per clock. A final adder combines the two partial sums into one full-precision result per sample.

The coefficients can be replaced while the filter runs. A host writes words one at a time into a shadow bank through an enable/address/data port. It then raises a load-done strobe. At a sample boundary, the whole shadow bank is copied into the active bank in a single clock, so no result is ever built from a mix of old and new coefficients. The timing of the strobe decides which sample is the first to use the new set. The delay line is never cleared by a reload.

Top module: `fir_prog_serial`

## Requirements
- R1: After reset, `result_valid` is low and `result_out` is zero. Every coefficient is zero until the first commit, so every result produced before that commit is zero.
- R2: The result for the sample taken at edge n is the sum over k = 0..10 of h[k]·x[n−k]. Inputs and coefficients are signed 16-bit with 15 fractional bits. The sum has 30 fractional bits and is sign-extended into the 36-bit output, with no rounding and no saturation. h[k] is the word at coefficient address k. Taps 0..6 run on the first partition and taps 7..10 on the second.
- R3: `result_valid` is a one-clock pulse. It is high right after the edge that lies 8 edges (ratio + 1) after each edge at which `sample_valid` was sampled high. `sample_valid` is high at exactly one edge in every 7.
- R4: At an edge where `coef_wr_en` is high, `coef_wr_data` is stored in the shadow bank at `coef_wr_addr`. Words may arrive in any address order. Shadow contents have no effect on results until a commit.
- R5: The strobe `coef_load_done` rises at edge c when it is high at c and was low at c−1. If the next sample edge s satisfies s ≥ c+2, the committed shadow set is used from the sample at s onward.
- R6: If that sample edge falls at s = c or s = c+1, the sample at s still uses the previous set. The new set takes effect from the following sample.
- R7: Only a rising edge of `coef_load_done` requests a commit. Holding the strobe high for any number of clocks causes no further commit. Shadow writes made while it stays high do not reach the results until a new rising edge.
- R8: A commit leaves the delay line untouched. The first result after a switch combines the new coefficients with samples taken before the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, ratio times the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | One-clock strobe marking a new input sample |
| sample_in | input | 16 | Signed Q1.15 input sample |
| coef_wr_en | input | 1 | Shadow-bank write enable |
| coef_wr_addr | input | 4 | Coefficient index to write |
| coef_wr_data | input | 16 | Signed Q1.15 coefficient word |
| coef_load_done | input | 1 | Load-done strobe; its rising edge requests a commit |
| result_valid | output | 1 | One-clock pulse per finished result |
| result_out | output | 36 | Signed full-precision sum, 30 fractional bits |

## Verification
The bench places the load-done rising edge exactly 0, 1 and 2 clocks ahead of a sample edge, and then at random gaps. A commit window that is off by one would apply a set one sample too early or too late, and the result of that boundary sample would not match. Extreme operands (all coefficients and samples at −1.0, then +max) expose a truncated product or an accumulator too narrow to hold eleven worst-case terms. The bench holds the strobe high while it rewrites the shadow bank, which catches a level-sensitive commit. It also writes the shadow bank without any strobe, which catches shadow words leaking into results early. Results that straddle each switch carry the old history, so a reload that cleared the delay line shows up at once.

// File: rtl/fir_prog_pkg.sv
package fir_prog_pkg;

    localparam int SAMPLE_W_DEF = 16;
    localparam int COEF_W_DEF   = 16;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // product width plus growth for the number of terms summed
    function automatic int sum_width(input int dw, input int cw, input int n);
        return dw + cw + $clog2(n);
    endfunction

    typedef struct packed {
        logic en;   // accumulate this clock
        logic clr;  // first tap of a sample: restart the sum
    } mac_ctl_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

endpackage

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
    parameter int NTAPS = 11,
    parameter int CW    = 16,
    parameter int AW    = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [CW-1:0]         wr_data,
    input  logic                  load_done,
    input  logic                  in_valid,
    output logic [NTAPS*CW-1:0]   act_flat
);

    logic [CW-1:0] shadow [NTAPS];
    logic [CW-1:0] active [NTAPS];
    logic          done_q, done_qq, pending, rise_seen;

    // rise is seen one clock after it occurs; pending follows one later,
    // so a sample edge needs the rise two edges ahead to commit.
    assign rise_seen = done_q & ~done_qq;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q  <= 1'b0;
            done_qq <= 1'b0;
            pending <= 1'b0;
            for (int i = 0; i < NTAPS; i++) begin
                shadow[i] <= '0;
                active[i] <= '0;
            end
        end else begin
            done_q  <= load_done;
            done_qq <= done_q;
            pending <= rise_seen | (pending & ~in_valid);
            for (int i = 0; i < NTAPS; i++) begin
                if (wr_en && wr_addr == AW'(i))
                    shadow[i] <= wr_data;
                if (in_valid && pending)
                    active[i] <= shadow[i];
            end
        end
    end

    for (genvar i = 0; i < NTAPS; i++) begin : g_flat
        assign act_flat[i*CW +: CW] = active[i];

        // R4
        shadow_write_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_addr == AW'(i)) |=> (shadow[i] == $past(wr_data)));
    end

    // R4
    active_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(act_flat));

endmodule

// File: rtl/fir_part_mac.sv
module fir_part_mac
    import fir_prog_pkg::*;
#(
    parameter int LEN  = 7,
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int PW   = 3,
    parameter int ACCW = 36,
    localparam int PRW = DW + CW
) (
    input  logic                   clk,
    input  logic                   rst,
    input  mac_ctl_t               ctl,
    input  logic [PW-1:0]          ph,
    input  logic [LEN*CW-1:0]      coefs,
    input  logic [LEN*DW-1:0]      taps,
    output logic signed [ACCW-1:0] acc
);

    logic signed [CW-1:0]   c_sel;
    logic signed [DW-1:0]   d_sel;
    logic signed [PRW-1:0]  prod;
    logic signed [ACCW-1:0] acc_n;

    // phases beyond this partition's length select zero operands
    always_comb begin
        c_sel = '0;
        d_sel = '0;
        for (int i = 0; i < LEN; i++) begin
            if (ph == PW'(i)) begin
                c_sel = coefs[i*CW +: CW];
                d_sel = taps[i*DW +: DW];
            end
        end
        prod  = c_sel * d_sel;
        acc_n = (ctl.clr ? '0 : acc) + {{(ACCW-PRW){prod[PRW-1]}}, prod};
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc <= '0;
        else if (ctl.en)
            acc <= acc_n;
    end

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl.en |=> $stable(acc));

endmodule

// File: rtl/fir_prog_serial.sv
module fir_prog_serial
    import fir_prog_pkg::*;
#(
    parameter int PART0_LEN = 7,
    parameter int PART1_LEN = 4,
    parameter int DATA_W    = SAMPLE_W_DEF,
    parameter int COEF_W    = COEF_W_DEF,
    localparam int NTAPS    = PART0_LEN + PART1_LEN,
    localparam int AW       = $clog2(NTAPS),
    localparam int OUT_W    = sum_width(DATA_W, COEF_W, NTAPS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_valid,
    input  logic [DATA_W-1:0] sample_in,
    input  logic              coef_wr_en,
    input  logic [AW-1:0]     coef_wr_addr,
    input  logic [COEF_W-1:0] coef_wr_data,
    input  logic              coef_load_done,
    output logic              result_valid,
    output logic [OUT_W-1:0]  result_out
);

    localparam int NPART = 2;
    localparam int RATIO = imax(PART0_LEN, PART1_LEN);
    localparam int PW    = $clog2(RATIO);

    logic [DATA_W-1:0]        dline [NTAPS];
    logic [NTAPS*DATA_W-1:0]  taps_flat;
    logic [NTAPS*COEF_W-1:0]  act_flat;
    logic [PW-1:0]            ph;
    seq_state_t               st;
    logic                     fin;
    mac_ctl_t                 ctl;
    logic signed [OUT_W-1:0]  psum [NPART];
    logic signed [OUT_W-1:0]  total;

    // delay line: shifts only on a new sample, never on a coefficient switch
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NTAPS; i++) dline[i] <= '0;
        end else if (sample_valid) begin
            dline[0] <= sample_in;
            for (int i = 1; i < NTAPS; i++) dline[i] <= dline[i-1];
        end
    end

    for (genvar i = 0; i < NTAPS; i++) begin : g_taps
        assign taps_flat[i*DATA_W +: DATA_W] = dline[i];
    end

    // tap sequencer shared by all partitions
    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SEQ_IDLE;
            ph  <= '0;
            fin <= 1'b0;
        end else begin
            fin <= (st == SEQ_RUN) && (ph == PW'(RATIO-1));
            if (sample_valid) begin
                st <= SEQ_RUN;
                ph <= '0;
            end else if (st == SEQ_RUN) begin
                if (ph == PW'(RATIO-1)) begin
                    st <= SEQ_IDLE;
                    ph <= '0;
                end else begin
                    ph <= ph + 1'b1;
                end
            end
        end
    end

    assign ctl.en  = (st == SEQ_RUN);
    assign ctl.clr = (ph == '0);

    fir_coef_bank #(.NTAPS(NTAPS), .CW(COEF_W), .AW(AW)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (coef_wr_en),
        .wr_addr  (coef_wr_addr),
        .wr_data  (coef_wr_data),
        .load_done(coef_load_done),
        .in_valid (sample_valid),
        .act_flat (act_flat)
    );

    for (genvar g = 0; g < NPART; g++) begin : g_part
        localparam int L = (g == 0) ? PART0_LEN : PART1_LEN;
        localparam int B = (g == 0) ? 0 : PART0_LEN;
        fir_part_mac #(.LEN(L), .DW(DATA_W), .CW(COEF_W), .PW(PW), .ACCW(OUT_W)) u_mac (
            .clk  (clk),
            .rst  (rst),
            .ctl  (ctl),
            .ph   (ph),
            .coefs(act_flat[B*COEF_W +: L*COEF_W]),
            .taps (taps_flat[B*DATA_W +: L*DATA_W]),
            .acc  (psum[g])
        );
    end

    always_comb begin
        total = '0;
        for (int g = 0; g < NPART; g++) total = total + psum[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_valid <= 1'b0;
            result_out   <= '0;
        end else begin
            result_valid <= fin;
            if (fin) result_out <= total;
        end
    end

    // R3
    result_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    // R3
    phase_range_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(ph) < RATIO));

    // R8
    dline_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |=> $stable(taps_flat));

endmodule

// File: tb/fir_prog_serial_test.sv
`timescale 1ns/1ps
module fir_prog_serial_test;

    localparam int RATIO = 7;
    localparam int NT    = 11;
    localparam int MAXC  = 8192;

    logic        clk = 1'b0;
    logic        rst;
    logic        sample_valid;
    logic [15:0] sample_in;
    logic        coef_wr_en;
    logic [3:0]  coef_wr_addr;
    logic [15:0] coef_wr_data;
    logic        coef_load_done;
    logic        result_valid;
    logic [35:0] result_out;

    always #2.5 clk = ~clk;

    fir_prog_serial uut (
        .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample_in(sample_in),
        .coef_wr_en(coef_wr_en), .coef_wr_addr(coef_wr_addr), .coef_wr_data(coef_wr_data),
        .coef_load_done(coef_load_done), .result_valid(result_valid), .result_out(result_out)
    );

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    int slot = 0;
    string cur_req = "R1";
    bit done_lvl = 0;
    bit use_fx = 0;
    logic [15:0] fx = '0;

    logic signed [15:0] sh_m [NT];
    logic signed [15:0] act_m [NT];
    logic signed [15:0] dl_m [NT];
    logic signed [15:0] setv [NT];
    bit    pend_m = 0;
    int    pend_edge = 0;
    bit    done_prev = 0;
    bit    exp_v [MAXC];
    longint exp_y [MAXC];
    string exp_tag [MAXC];

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d (edge %0d)", req, act, exp, cyc);
        end
    endtask

    // one clock: drive before the edge, update the model, sample after it
    task automatic tick(input bit we, input int wa, input logic [15:0] wd, input bit done);
        bit iv;
        logic [15:0] x;
        int e;
        longint acc;
        @(negedge clk);
        iv = (slot == 0);
        x  = use_fx ? fx : 16'($urandom);
        sample_valid   = iv;
        sample_in      = x;
        coef_wr_en     = we;
        coef_wr_addr   = 4'(wa);
        coef_wr_data   = wd;
        coef_load_done = done;
        e = cyc + 1;
        if (iv) begin
            if (pend_m && pend_edge <= e - 2) begin
                for (int k = 0; k < NT; k++) act_m[k] = sh_m[k];
                pend_m = 0;
            end
            for (int k = NT-1; k > 0; k--) dl_m[k] = dl_m[k-1];
            dl_m[0] = x;
            acc = 0;
            for (int k = 0; k < NT; k++) acc += longint'(act_m[k]) * longint'(dl_m[k]);
            if (e + RATIO + 1 < MAXC) begin
                exp_v[e+RATIO+1]   = 1;
                exp_y[e+RATIO+1]   = acc;
                exp_tag[e+RATIO+1] = cur_req;
            end
        end
        if (done && !done_prev && !pend_m) begin
            pend_m = 1;
            pend_edge = e;
        end
        if (we && wa < NT) sh_m[wa] = wd;
        done_prev = done;
        @(posedge clk);
        cyc++;
        #1;
        if (cyc < MAXC && (exp_v[cyc] || result_valid)) begin
            check(result_valid == exp_v[cyc], "R3", longint'(result_valid), longint'(exp_v[cyc]));
            if (exp_v[cyc])
                check(longint'($signed(result_out)) == exp_y[cyc], exp_tag[cyc],
                      longint'($signed(result_out)), exp_y[cyc]);
        end
        slot = (slot == RATIO-1) ? 0 : slot + 1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, '0, done_lvl);
    endtask

    task automatic write_set(input bit rev);
        for (int i = 0; i < NT; i++) begin
            int a;
            a = rev ? (NT-1-i) : i;
            tick(1, a, setv[a], done_lvl);
        end
    endtask

    task automatic rand_set();
        for (int i = 0; i < NT; i++) setv[i] = 16'($urandom);
    endtask

    // rising edge of the load strobe placed g edges ahead of a sample edge
    task automatic commit_at_gap(input int g, input bit hold);
        done_lvl = 0;
        tick(0, 0, '0, 0);
        while (((RATIO - slot) % RATIO) != g) tick(0, 0, '0, 0);
        tick(0, 0, '0, 1);
        done_lvl = hold;
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int k = 0; k < NT; k++) begin
            sh_m[k] = '0; act_m[k] = '0; dl_m[k] = '0;
        end
        for (int c = 0; c < MAXC; c++) begin
            exp_v[c] = 0; exp_y[c] = 0; exp_tag[c] = "R3";
        end
        rst = 1; sample_valid = 0; sample_in = '0;
        coef_wr_en = 0; coef_wr_addr = '0; coef_wr_data = '0; coef_load_done = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R1: reset state at the ports
        check(result_valid == 1'b0, "R1", longint'(result_valid), 0);
        check(result_out == '0, "R1", longint'($signed(result_out)), 0);

        // R1: zero coefficients before any commit
        cur_req = "R1";
        idle(4 * RATIO);

        // R4: shadow loaded in reverse order, no strobe: results stay zero
        cur_req = "R4";
        rand_set();
        write_set(1);
        idle(3 * RATIO);

        // R5: strobe rises exactly two edges ahead of a sample
        cur_req = "R5";
        commit_at_gap(2, 0);
        // R8: results straddling the switch use earlier history
        cur_req = "R8";
        idle(2 * RATIO);
        cur_req = "R2";
        idle(6 * RATIO);

        // R2: extreme operands
        for (int i = 0; i < NT; i++) setv[i] = 16'h8000;
        write_set(0);
        commit_at_gap(3, 0);
        use_fx = 1; fx = 16'h8000;
        idle(13 * RATIO);
        fx = 16'h7FFF;
        idle(13 * RATIO);
        use_fx = 0;
        rand_set();
        write_set(0);
        commit_at_gap(5, 0);
        idle(4 * RATIO);

        // R6: strobe one edge ahead, then at the sample edge itself
        cur_req = "R6";
        rand_set();
        write_set(0);
        commit_at_gap(1, 0);
        idle(3 * RATIO);
        rand_set();
        write_set(1);
        commit_at_gap(0, 0);
        idle(3 * RATIO);

        // R7: strobe held high while the shadow bank is rewritten
        cur_req = "R7";
        rand_set();
        write_set(0);
        commit_at_gap(4, 1);
        idle(2 * RATIO);
        rand_set();
        write_set(0);
        idle(4 * RATIO);
        done_lvl = 0;
        idle(3 * RATIO);
        commit_at_gap(2, 0);
        idle(3 * RATIO);

        // random gaps
        for (int r = 0; r < 8; r++) begin
            int g;
            g = int'($urandom % RATIO);
            cur_req = (g >= 2) ? "R5" : "R6";
            rand_set();
            write_set($urandom % 2 == 1);
            commit_at_gap(g, ($urandom % 2) == 1);
            idle(2 * RATIO + int'($urandom % 9));
        end
        done_lvl = 0;
        idle(3 * RATIO);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL R3 watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule